// File: doc/BRIEF.md
# Inter-processor send command dispatcher

This block takes 64-bit send commands issued by a core and turns each one into work on the register file of a target core. The target is named by a 10-bit core number inside the command. A command of the interrupt kind asks the target to set one pending-interrupt bit. A command of the mailbox kind stores a 32-bit word into one of eight mailbox words of the target. A command of the raw kind stores a 32-bit word at any 16-bit register offset of the target.

Mailbox and raw stores can keep chosen bytes of the word already in the target. A four-bit keep mask in the command selects those bytes. When the mask is nonzero the dispatcher first reads the target word over its register port, merges the two, and then writes the result. When the mask is zero it writes the payload once, with no read. The dispatcher handles one command at a time and shows this on a busy output. A command that names a core that does not exist, that uses the reserved kind code, or that receives an error from the register port ends with a fault pulse. Every fault also sets an error flag that stays high until reset.

Top module: `ipi_send_dispatch`

## Requirements
- R1: After reset, busy_o, done_o, fault_o, err_sticky_o, ipi_set_valid_o and tgt_req_valid_o are all 0.
- R2: The target core number is command bits [25:16]. If it is not below NUM_CORES, the command makes no register-port request and no set request, and it ends with done_o and fault_o both high.
- R3: Kind code 0 (interrupt) makes no register-port request. In its done_o cycle it raises ipi_set_valid_o for one cycle, with ipi_set_core_o set to the target and ipi_set_vec_o set to command bits [4:0].
- R4: Kind code 1 (mailbox) addresses offset MAIL_BASE + 4 * command bits [4:2], where MAIL_BASE defaults to 0x20.
- R5: Kind code 2 (raw) addresses the offset held in command bits [15:0].
- R6: The payload is command bits [63:32]. When the keep mask (command bits [30:27]) is zero, the block issues exactly one write request carrying the payload and no read.
- R7: When the keep mask is nonzero, the block issues a read and then a write to the same offset. In the written word, byte i is the old byte when mask bit i (command bit 27+i) is set, and the payload byte otherwise.
- R8: A register-port request holds its valid, direction, core, offset and data stable until a cycle in which tgt_rsp_valid_i is high.
- R9: A response with tgt_rsp_err_i set ends the command: no further request is made, and done_o comes with fault_o.
- R10: busy_o is high from the cycle after a command is accepted through its done_o cycle. cmd_valid_i is ignored while busy_o is high.
- R11: Kind code 3 is reserved. It makes no request of any kind and ends with a fault.
- R12: err_sticky_o goes high with the first fault and stays high until reset.
- R13: Every accepted command produces exactly one single-cycle done_o pulse. fault_o is high only in that cycle, and only for a failed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present; taken when busy_o is low |
| cmd_kind_i | input | 2 | 0 interrupt, 1 mailbox, 2 raw offset, 3 reserved |
| cmd_data_i | input | 64 | Packed send command |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| fault_o | output | 1 | The ending command failed (valid with done_o) |
| err_sticky_o | output | 1 | Some command has failed since reset |
| ipi_set_valid_o | output | 1 | Set-pending-bit request to a target |
| ipi_set_core_o | output | 10 | Target core of the set request |
| ipi_set_vec_o | output | 5 | Bit number to set |
| tgt_req_valid_o | output | 1 | Register-port request valid |
| tgt_req_write_o | output | 1 | 1 write, 0 read |
| tgt_req_core_o | output | 10 | Target core of the register access |
| tgt_req_addr_o | output | 16 | Register offset on the target |
| tgt_req_wdata_o | output | 32 | Write data |
| tgt_rsp_valid_i | input | 1 | Response; completes the current request |
| tgt_rsp_err_i | input | 1 | Response carries an error |
| tgt_rsp_rdata_i | input | 32 | Read data |

## Verification
The bench builds the dispatcher with NUM_CORES = 5. This makes core 4 the last valid target and core 5 the first invalid one, so both sides of the range check are exercised next to each other. Core 1023 tests the top of the field. MAIL_BASE stays at 0x20, which lets mailbox indices 0 and 7 reach both ends of the mailbox window. The bench target answers with a two-cycle delay, so requests must be held across idle response cycles. The bench also injects errors on a chosen offset, which aborts a command during its read and during its write.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;

    localparam int CMD_W    = 64;
    localparam int CORE_W   = 10;
    localparam int OFS_W    = 16;
    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
    localparam int VEC_W    = 5;

    // command field positions (the command format is fixed)
    localparam int CORE_LSB = 16;
    localparam int KEEP_LSB = 27;
    localparam int PAY_LSB  = 32;
    localparam int MBOX_LSB = 2;
    localparam int MBOX_W   = 3;

    typedef enum logic [1:0] {
        KIND_IPI  = 2'd0,
        KIND_MAIL = 2'd1,
        KIND_RAW  = 2'd2,
        KIND_RSVD = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } disp_st_e;

    typedef struct packed {
        disp_st_e            st;
        cmd_kind_e           kind;
        logic [CORE_W-1:0]   core;
        logic [VEC_W-1:0]    vec;
        logic [OFS_W-1:0]    addr;
        logic [LANES-1:0]    keep;
        logic [WORD_W-1:0]   data;
        logic                fault;
        logic                sticky;
    } disp_ctx_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_disp_pkg::*;
#(
    parameter int              NUM_CORES = 4,
    parameter logic [OFS_W-1:0] MAIL_BASE = 16'h0020
) (
    input  cmd_kind_e          kind_i,
    input  logic [CMD_W-1:0]   cmd_i,
    output logic [CORE_W-1:0]  core_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [OFS_W-1:0]   addr_o,
    output logic [LANES-1:0]   keep_o,
    output logic [WORD_W-1:0]  pay_o,
    output logic               id_ok_o,
    output logic               kind_ok_o
);

    localparam logic [CORE_W:0] CORE_LIM = (CORE_W+1)'(NUM_CORES);

    logic [MBOX_W-1:0] mbox_idx;
    logic [OFS_W-1:0]  mail_addr;
    logic              unused_cmd_bits;

    assign core_o    = cmd_i[CORE_LSB +: CORE_W];
    assign vec_o     = cmd_i[VEC_W-1:0];
    assign keep_o    = cmd_i[KEEP_LSB +: LANES];
    assign pay_o     = cmd_i[PAY_LSB +: WORD_W];
    assign mbox_idx  = cmd_i[MBOX_LSB +: MBOX_W];
    assign mail_addr = MAIL_BASE + {{(OFS_W-MBOX_W-2){1'b0}}, mbox_idx, 2'b00};
    assign unused_cmd_bits = ^{cmd_i[31], cmd_i[26]};

    always_comb begin
        id_ok_o   = ({1'b0, core_o} < CORE_LIM);
        kind_ok_o = (kind_i != KIND_RSVD);
        addr_o    = (kind_i == KIND_MAIL) ? mail_addr : cmd_i[OFS_W-1:0];
    end

endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
    import ipi_disp_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [NLANES*8-1:0] old_i,
    input  logic [NLANES*8-1:0] new_i,
    input  logic [NLANES-1:0]   keep_i,
    output logic [NLANES*8-1:0] merged_o
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign merged_o[g*8 +: 8] = keep_i[g] ? old_i[g*8 +: 8] : new_i[g*8 +: 8];
    end

endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
    import ipi_disp_pkg::*;
#(
    parameter int              NUM_CORES = 4,
    parameter logic [15:0]     MAIL_BASE = 16'h0020
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid_i,
    input  logic [1:0]         cmd_kind_i,
    input  logic [63:0]        cmd_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               fault_o,
    output logic               err_sticky_o,
    output logic               ipi_set_valid_o,
    output logic [9:0]         ipi_set_core_o,
    output logic [4:0]         ipi_set_vec_o,
    output logic               tgt_req_valid_o,
    output logic               tgt_req_write_o,
    output logic [9:0]         tgt_req_core_o,
    output logic [15:0]        tgt_req_addr_o,
    output logic [31:0]        tgt_req_wdata_o,
    input  logic               tgt_rsp_valid_i,
    input  logic               tgt_rsp_err_i,
    input  logic [31:0]        tgt_rsp_rdata_i
);

    disp_ctx_t ctx_d, ctx_q;

    cmd_kind_e          kind_in;
    logic [CORE_W-1:0]  dec_core;
    logic [VEC_W-1:0]   dec_vec;
    logic [OFS_W-1:0]   dec_addr;
    logic [LANES-1:0]   dec_keep;
    logic [WORD_W-1:0]  dec_pay;
    logic               dec_id_ok;
    logic               dec_kind_ok;
    logic [WORD_W-1:0]  merged;

    assign kind_in = cmd_kind_e'(cmd_kind_i);

    ipi_cmd_decode #(
        .NUM_CORES (NUM_CORES),
        .MAIL_BASE (MAIL_BASE)
    ) u_decode (
        .kind_i    (kind_in),
        .cmd_i     (cmd_data_i),
        .core_o    (dec_core),
        .vec_o     (dec_vec),
        .addr_o    (dec_addr),
        .keep_o    (dec_keep),
        .pay_o     (dec_pay),
        .id_ok_o   (dec_id_ok),
        .kind_ok_o (dec_kind_ok)
    );

    ipi_byte_merge #(
        .NLANES (LANES)
    ) u_merge (
        .old_i    (tgt_rsp_rdata_i),
        .new_i    (ctx_q.data),
        .keep_i   (ctx_q.keep),
        .merged_o (merged)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    ctx_d.kind  = kind_in;
                    ctx_d.core  = dec_core;
                    ctx_d.vec   = dec_vec;
                    ctx_d.addr  = dec_addr;
                    ctx_d.keep  = dec_keep;
                    ctx_d.data  = dec_pay;
                    ctx_d.fault = 1'b0;
                    if (!dec_kind_ok || !dec_id_ok) begin
                        ctx_d.fault  = 1'b1;
                        ctx_d.sticky = 1'b1;
                        ctx_d.st     = ST_DONE;
                    end else if (kind_in == KIND_IPI) begin
                        ctx_d.st = ST_DONE;
                    end else if (dec_keep != '0) begin
                        ctx_d.st = ST_READ;
                    end else begin
                        ctx_d.st = ST_WRITE;
                    end
                end
            end
            ST_READ: begin
                if (tgt_rsp_valid_i) begin
                    if (tgt_rsp_err_i) begin
                        ctx_d.fault  = 1'b1;
                        ctx_d.sticky = 1'b1;
                        ctx_d.st     = ST_DONE;
                    end else begin
                        ctx_d.data = merged;
                        ctx_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (tgt_rsp_valid_i) begin
                    if (tgt_rsp_err_i) begin
                        ctx_d.fault  = 1'b1;
                        ctx_d.sticky = 1'b1;
                    end
                    ctx_d.st = ST_DONE;
                end
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        busy_o          = (ctx_q.st != ST_IDLE);
        done_o          = (ctx_q.st == ST_DONE);
        fault_o         = done_o && ctx_q.fault;
        err_sticky_o    = ctx_q.sticky;
        ipi_set_valid_o = done_o && !ctx_q.fault && (ctx_q.kind == KIND_IPI);
        ipi_set_core_o  = ctx_q.core;
        ipi_set_vec_o   = ctx_q.vec;
        tgt_req_valid_o = (ctx_q.st == ST_READ) || (ctx_q.st == ST_WRITE);
        tgt_req_write_o = (ctx_q.st == ST_WRITE);
        tgt_req_core_o  = ctx_q.core;
        tgt_req_addr_o  = ctx_q.addr;
        tgt_req_wdata_o = ctx_q.data;
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_valid_o && !tgt_rsp_valid_i |=> tgt_req_valid_o && $stable(tgt_req_write_o)
        && $stable(tgt_req_addr_o) && $stable(tgt_req_core_o) && $stable(tgt_req_wdata_o)); // R8

    AST_READ_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_valid_o && !tgt_req_write_o |-> ctx_q.keep != '0); // R6

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_valid_o && !tgt_req_write_o && tgt_rsp_valid_i && !tgt_rsp_err_i
        |=> tgt_req_valid_o && tgt_req_write_o && $stable(tgt_req_addr_o)); // R7

    AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_valid_o && tgt_rsp_valid_i && tgt_rsp_err_i
        |=> done_o && fault_o && !tgt_req_valid_o); // R9

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky_o |=> err_sticky_o); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !fault_o); // R13

    AST_SET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_set_valid_o |-> ({1'b0, ipi_set_core_o} < (CORE_W+1)'(NUM_CORES))); // R2

endmodule

// File: tb/ipi_send_dispatch_bench.sv
module ipi_send_dispatch_bench;

    localparam int NC  = 5;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [63:0] cmd_data = '0;
    logic        busy, done, fault, sticky;
    logic        set_valid;
    logic [9:0]  set_core;
    logic [4:0]  set_vec;
    logic        req_valid, req_write;
    logic [9:0]  req_core;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;

    always #4 clk = ~clk;

    ipi_send_dispatch #(.NUM_CORES(NC), .MAIL_BASE(16'h0020)) u_ipi_send_dispatch (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind), .cmd_data_i(cmd_data),
        .busy_o(busy), .done_o(done), .fault_o(fault), .err_sticky_o(sticky),
        .ipi_set_valid_o(set_valid), .ipi_set_core_o(set_core), .ipi_set_vec_o(set_vec),
        .tgt_req_valid_o(req_valid), .tgt_req_write_o(req_write), .tgt_req_core_o(req_core),
        .tgt_req_addr_o(req_addr), .tgt_req_wdata_o(req_wdata),
        .tgt_rsp_valid_i(rsp_valid), .tgt_rsp_err_i(rsp_err), .tgt_rsp_rdata_i(rsp_rdata)
    );

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit exp_sticky = 0;
    int err_key = -1;

    bit [31:0] mem [int];
    bit        q_w [$];
    int        q_c [$];
    int        q_a [$];
    bit [31:0] q_d [$];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic bit [31:0] word_at(input int key);
        if (mem.exists(key)) return mem[key];
        return (32'(key) * 32'h0101_0101) ^ 32'hA5C3_0000;
    endfunction

    // behavioural target: answers each request LAT cycles after it appears
    int wait_cnt = 0;
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_err <= 1'b0; wait_cnt = 0;
        end else if (rsp_valid) begin
            rsp_valid <= 1'b0; rsp_err <= 1'b0; wait_cnt = 0;
        end else if (req_valid) begin
            if (q_w.size() == 0) begin
                chk(0, "R10 unexpected request", req_addr, 0);
            end else begin
                chk(req_write == q_w[0], "R7 request direction", req_write, q_w[0]);
                chk(req_core == 10'(q_c[0]), "R2 request core", req_core, q_c[0]);
                chk(req_addr == 16'(q_a[0]), "R8 request offset", req_addr, q_a[0]);
                if (q_w[0])
                    chk(req_wdata == q_d[0], "R6 write data", req_wdata, q_d[0]);
            end
            wait_cnt++;
            if (wait_cnt >= LAT) begin
                int key;
                key = int'(req_core) * 65536 + int'(req_addr);
                rsp_valid <= 1'b1;
                if (key == err_key) begin
                    rsp_err <= 1'b1;
                    q_w.delete(); q_c.delete(); q_a.delete(); q_d.delete();
                end else begin
                    if (req_write) mem[key] = req_wdata;
                    else rsp_rdata <= word_at(key);
                    if (q_w.size() != 0) begin
                        void'(q_w.pop_front()); void'(q_c.pop_front());
                        void'(q_a.pop_front()); void'(q_d.pop_front());
                    end
                end
            end
        end
        if (set_valid)
            chk(done, "R3 set request outside done", set_valid, 0);
    end

    task automatic run_cmd(input bit [1:0] kind, input bit [63:0] d, input bit err_exp);
        int core, addr, key, n;
        bit [3:0] keep;
        bit [31:0] pay, old, mrg;
        bit exp_fault;
        core = int'(d[25:16]);
        keep = d[30:27];
        pay  = d[63:32];
        addr = (kind == 2'd1) ? (32 + 4 * int'(d[4:2])) : int'(d[15:0]);
        key  = core * 65536 + addr;
        exp_fault = (kind == 2'd3) || (core >= NC) || err_exp;
        if (kind != 2'd3 && core < NC && kind != 2'd0) begin
            if (keep != 0) begin
                old = word_at(key);
                for (int i = 0; i < 4; i++)
                    mrg[i*8 +: 8] = keep[i] ? old[i*8 +: 8] : pay[i*8 +: 8];
                q_w.push_back(0); q_c.push_back(core); q_a.push_back(addr); q_d.push_back(0);
                q_w.push_back(1); q_c.push_back(core); q_a.push_back(addr); q_d.push_back(mrg);
            end else begin
                q_w.push_back(1); q_c.push_back(core); q_a.push_back(addr); q_d.push_back(pay);
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cmd_data = d;
        @(negedge clk);
        chk(busy, "R10 busy after accept", busy, 1);
        cmd_kind = 2'd2; cmd_data = 64'h5A5A5A5A_0000_7777;   // must be ignored
        n = 0;
        while (!done && n < 50) begin
            @(negedge clk); cmd_valid = 1'b0; n++;
        end
        chk(done, "R13 done reached", done, 1);
        chk(fault == exp_fault, "R9 fault on done", fault, exp_fault);
        exp_sticky |= exp_fault;
        chk(sticky == exp_sticky, "R12 sticky flag", sticky, exp_sticky);
        chk(set_valid == (kind == 2'd0 && !exp_fault), "R3 set request", set_valid, (kind == 2'd0 && !exp_fault));
        if (kind == 2'd0 && !exp_fault) begin
            chk(set_core == d[25:16], "R3 set core", set_core, d[25:16]);
            chk(set_vec == d[4:0], "R3 set vector", set_vec, d[4:0]);
        end
        chk(q_w.size() == 0, "R6 all requests issued", q_w.size(), 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!done && !fault, "R13 single done pulse", done, 0);
        @(negedge clk);
        chk(!busy && !req_valid, "R10 command during busy ignored", busy, 0);
        err_key = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !sticky && !set_valid && !req_valid, "R1 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 interrupt sends, boundary core and vector
        run_cmd(2'd0, {32'hFFFF_FFFF, 6'd0, 10'd0, 11'd0, 5'd0}, 0);
        run_cmd(2'd0, {32'h0, 6'd0, 10'd4, 11'd0, 5'd31}, 0);
        // R4 mailbox words 0 and 7, no keep mask (R6)
        run_cmd(2'd1, {32'h1122_3344, 1'b0, 4'b0000, 1'b0, 10'd1, 11'd0, 3'd0, 2'd0}, 0);
        run_cmd(2'd1, {32'hDEAD_BEEF, 1'b0, 4'b0000, 1'b0, 10'd3, 11'd0, 3'd7, 2'd0}, 0);
        // R5 raw offset
        run_cmd(2'd2, {32'hCAFE_F00D, 1'b0, 4'b0000, 1'b0, 10'd2, 16'h1234}, 0);
        // R7 keep masks
        run_cmd(2'd1, {32'hAABB_CCDD, 1'b0, 4'b0101, 1'b0, 10'd1, 11'd0, 3'd3, 2'd0}, 0);
        run_cmd(2'd2, {32'h0102_0304, 1'b0, 4'b1111, 1'b0, 10'd2, 16'h1234}, 0);
        run_cmd(2'd2, {32'h9988_7766, 1'b0, 4'b1000, 1'b0, 10'd2, 16'h1234}, 0);
        run_cmd(2'd1, {32'h5555_6666, 1'b0, 4'b0010, 1'b0, 10'd3, 11'd0, 3'd7, 2'd0}, 0);
        // R2 out-of-range cores
        run_cmd(2'd2, {32'h1, 1'b0, 4'b0000, 1'b0, 10'd5, 16'h0040}, 0);
        run_cmd(2'd0, {32'h1, 6'd0, 10'd1023, 11'd0, 5'd7}, 0);
        // R11 reserved kind
        run_cmd(2'd3, {32'h1, 1'b0, 4'b0000, 1'b0, 10'd0, 16'h0040}, 0);
        // R9 error on read, then on write
        err_key = 1 * 65536 + 32'h2C;
        run_cmd(2'd1, {32'h7777_8888, 1'b0, 4'b0001, 1'b0, 10'd1, 11'd0, 3'd3, 2'd0}, 1);
        err_key = 4 * 65536 + 32'h0100;
        run_cmd(2'd2, {32'h4444_3333, 1'b0, 4'b0000, 1'b0, 10'd4, 16'h0100}, 1);
        // R12 flag persists across a good command
        run_cmd(2'd2, {32'h0BAD_F00D, 1'b0, 4'b1100, 1'b0, 10'd4, 16'h0104}, 0);
        // R12 cleared by reset
        rst_n = 1'b0; exp_sticky = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sticky && !busy, "R12 sticky cleared by reset", sticky, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule